// File: doc/BRIEF.md
# Laser Fault Supervisor

This block watches the monitor-error indication of a laser transmitter. It declares a fault only when that error has stayed present for a programmable number of clock cycles. The default setting corresponds to about 2 ms at 200 MHz. The cycle counter takes the place of a timing capacitor. Once a fault is latched, the block drops the modulation-disable output low and removes the laser drive enable. The fault stays latched until the laser-on request is withdrawn.

The laser drive enable needs three things at once: the power-on permission input is high, the active-low laser-on request is asserted, and no fault is latched. A system or an external open-fiber controller can therefore switch the laser off at any time. Withdrawing the laser-on request also clears a latched fault and restarts the persistence count. When the fault latch sets, the block gives a single-cycle event pulse for an interrupt controller.

Each of the three inputs passes through its own two-flop synchroniser. The active-low reset asserts asynchronously and is released on a clock edge.

Top module: `laser_fault_sup`

## Requirements
- R1: After reset, fault_o = 0, fault_evt_o = 0, drv_en_o = 0 and mod_dis_n_o = 1.
- R2: A fault is latched once the synchronised error input has been sampled high on PERSIST_CYC consecutive clock edges while the laser-on request is asserted. If mon_err_i rises before clock edge 1, fault_o is still 0 after edge PERSIST_CYC+1 and is 1 after edge PERSIST_CYC+2.
- R3: If the error input goes low before the count completes, the count restarts from zero. Two runs of PERSIST_CYC-1 high samples separated by a low sample never latch a fault.
- R4: A latched fault stays latched when the error input goes away. While the fault is latched, mod_dis_n_o is 0 and drv_en_o is 0.
- R5: Deasserting laser_on_n_i (driving it to 1) clears the fault within 3 clock edges. While laser_on_n_i is 1, the persistence count is held at zero, so an error present during that time never latches a fault.
- R6: drv_en_o equals pwr_ok_i AND NOT laser_on_n_i AND NOT fault_o, with both inputs delayed by two clock edges. If they change before edge 1, drv_en_o changes after edge 2.
- R7: While pwr_ok_i is held low, drv_en_o stays 0 whatever the other inputs do.
- R8: fault_evt_o is 1 for exactly one cycle, and that cycle is the first cycle in which fault_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mon_err_i | input | 1 | Laser monitor error indication, asynchronous |
| laser_on_n_i | input | 1 | Active-low laser-on request; 1 turns the laser off and clears a fault |
| pwr_ok_i | input | 1 | Power-on permission for the laser driver; 0 disables it |
| fault_o | output | 1 | Latched fault flag |
| fault_evt_o | output | 1 | Single-cycle pulse when the fault latch sets |
| drv_en_o | output | 1 | Laser drive enable |
| mod_dis_n_o | output | 1 | Modulation-disable control, forced low while a fault is latched |

## Verification
The assertions assume that each input holds its level across a whole clock period. They also assume that a change at an input reaches the core exactly two edges later, so properties can relate the outputs to the inputs with a fixed two-cycle $past. The bench respects this by changing inputs only at falling clock edges, never between them. The random stimulus produces error runs both shorter and longer than the persistence window, plus occasional laser-off pulses and power drops, so faults are set, missed and cleared many times.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  // Synchronised view of the three asynchronous inputs.
  typedef struct packed {
    logic err;
    logic off;   // laser-on request withdrawn (active-high form of laser_on_n)
    logic pwr;
  } lfs_in_t;

  localparam int unsigned LFS_IN_W = $bits(lfs_in_t);
  // Reset values: no error, laser off, no power permission.
  localparam logic [LFS_IN_W-1:0] LFS_IN_RST = {1'b0, 1'b1, 1'b0};
endpackage

// File: rtl/lfs_rst_sync.sv
module lfs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lfs_sync2.sv
module lfs_sync2 #(
  parameter int unsigned        WIDTH   = 3,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        stab_q <= meta_q;
      end
    end
    assign q_o[b] = stab_q;
  end
endmodule

// File: rtl/lfs_persist_timer.sv
module lfs_persist_timer #(
  parameter int unsigned PERSIST_CYC = 400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  input  logic hold_i,    // keep the count at zero (laser off or fault latched)
  output logic expire_o   // last consecutive error sample of the window
);
  localparam int unsigned CNT_W = (PERSIST_CYC > 2) ? $clog2(PERSIST_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = err_i && !hold_i && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i || !err_i || at_last) cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lfs_fault_latch.sv
module lfs_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,    // clear wins over set
  output logic fault_o,
  output logic evt_o
);
  logic fault_q, fault_d;
  logic evt_q, evt_d;

  always_comb begin
    fault_d = fault_q;
    if (clr_i)      fault_d = 1'b0;
    else if (set_i) fault_d = 1'b1;
    evt_d = fault_d && !fault_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      fault_q <= fault_d;
      evt_q   <= evt_d;
    end
  end

  assign fault_o = fault_q;
  assign evt_o   = evt_q;
endmodule

// File: rtl/laser_fault_sup.sv
module laser_fault_sup #(
  parameter int unsigned PERSIST_CYC = 400_000,  // about 2 ms at 200 MHz
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_err_i,
  input  logic laser_on_n_i,
  input  logic pwr_ok_i,
  output logic fault_o,
  output logic fault_evt_o,
  output logic drv_en_o,
  output logic mod_dis_n_o
);
  import lfs_pkg::*;

  logic    rst_core_n;
  lfs_in_t in_raw, in_s;
  logic    expire;
  logic    fault;

  lfs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign in_raw = '{err: mon_err_i, off: laser_on_n_i, pwr: pwr_ok_i};

  lfs_sync2 #(.WIDTH(LFS_IN_W), .RST_VAL(LFS_IN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (in_raw),
    .q_o   (in_s)
  );

  lfs_persist_timer #(.PERSIST_CYC(PERSIST_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .err_i    (in_s.err),
    .hold_i   (in_s.off || fault),
    .expire_o (expire)
  );

  lfs_fault_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_i   (expire),
    .clr_i   (in_s.off),
    .fault_o (fault),
    .evt_o   (fault_evt_o)
  );

  assign fault_o     = fault;
  assign mod_dis_n_o = !fault;
  assign drv_en_o    = in_s.pwr && !in_s.off && !fault;
endmodule

// File: rtl/laser_fault_sup_chk.sv
module laser_fault_sup_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_err_i,
  input logic laser_on_n_i,
  input logic pwr_ok_i,
  input logic fault_o,
  input logic fault_evt_o,
  input logic drv_en_o,
  input logic mod_dis_n_o
);
  // R8: the event pulse lasts one cycle
  assert_evt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt_o |=> !fault_evt_o);

  // R8: the first fault cycle carries the event
  assert_evt_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !$past(fault_o)) |-> fault_evt_o);

  // R4: fault holds while the laser-on request stays asserted
  assert_fault_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !$past(laser_on_n_i, 2)) |=> fault_o);

  // R5: laser-off request clears the fault
  assert_off_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(laser_on_n_i, 2) |=> !fault_o);

  // R6 / R7: drive needs power permission two edges back
  assert_drv_needs_pwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en_o |-> $past(pwr_ok_i, 2));

  // R4: a latched fault blocks drive and modulation
  assert_fault_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!drv_en_o && !mod_dis_n_o));

  // R8: no event without mon_err having been high
  assert_evt_needs_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt_o |-> $past(mon_err_i, 3));
endmodule

bind laser_fault_sup laser_fault_sup_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mon_err_i    (mon_err_i),
  .laser_on_n_i (laser_on_n_i),
  .pwr_ok_i     (pwr_ok_i),
  .fault_o      (fault_o),
  .fault_evt_o  (fault_evt_o),
  .drv_en_o     (drv_en_o),
  .mod_dis_n_o  (mod_dis_n_o)
);

// File: tb/laser_fault_sup_tb_top.sv
`timescale 1ns/1ps
module laser_fault_sup_tb_top;
  localparam int unsigned P = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err = 1'b0, on_n = 1'b1, pwr = 1'b0;
  logic fault, evt, drv_en, mod_n;

  int n_chk = 0, n_fail = 0;
  bit sb_on = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  laser_fault_sup #(.PERSIST_CYC(P)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mon_err_i    (err),
    .laser_on_n_i (on_n),
    .pwr_ok_i     (pwr),
    .fault_o      (fault),
    .fault_evt_o  (evt),
    .drv_en_o     (drv_en),
    .mod_dis_n_o  (mod_n)
  );

  // ---------------- reference model built from the requirements -------------
  logic mr1, mr2;
  logic e1, e2, o1, o2, p1, p2;
  int   m_cnt;
  logic m_flt, m_evt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin mr1 <= 1'b0; mr2 <= 1'b0; end
    else        begin mr1 <= 1'b1; mr2 <= mr1; end
  end

  always @(posedge clk or negedge mr2) begin
    if (!mr2) begin
      e1 <= 0; e2 <= 0; o1 <= 1; o2 <= 1; p1 <= 0; p2 <= 0;
      m_cnt <= 0; m_flt <= 0; m_evt <= 0;
    end else begin
      e1 <= err; e2 <= e1; o1 <= on_n; o2 <= o1; p1 <= pwr; p2 <= p1;
      if (o2) begin
        m_cnt <= 0; m_flt <= 0; m_evt <= 0;
      end else if (m_flt) begin
        m_cnt <= 0; m_evt <= 0;
      end else if (e2) begin
        if (m_cnt == P - 1) begin m_cnt <= 0; m_flt <= 1; m_evt <= 1; end
        else begin m_cnt <= m_cnt + 1; m_evt <= 0; end
      end else begin
        m_cnt <= 0; m_evt <= 0;
      end
    end
  end

  function automatic logic exp_en(logic pw, logic off, logic flt);
    return pw && !off && !flt;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (sb_on) begin
      check("R2 fault_o", fault, m_flt);
      check("R8 fault_evt_o", evt, m_evt);
      check("R6 drv_en_o", drv_en, exp_en(p2, o2, m_flt));
      check("R4 mod_dis_n_o", mod_n, !m_flt);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(150_000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd7411));
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    check("R1 fault", fault, 0);
    check("R1 evt", evt, 0);
    check("R1 drv_en", drv_en, 0);
    check("R1 mod_dis_n", mod_n, 1);
    sb_on = 1'b1;

    // R7: no power permission keeps drive off
    on_n = 1'b0;
    tick(6);
    check("R7 drv_en with pwr low", drv_en, 0);

    // R6: enable latency of two edges
    pwr = 1'b1;
    tick(1);
    check("R6 drv_en one edge", drv_en, 0);
    tick(1);
    check("R6 drv_en two edges", drv_en, 1);

    // R2: persistence window and exact latch latency
    err = 1'b1;
    tick(P + 1);
    check("R2 no fault yet", fault, 0);
    tick(1);
    check("R2 fault latched", fault, 1);
    check("R8 event pulse", evt, 1);
    tick(1);
    check("R8 event ends", evt, 0);

    // R4: fault persists after the error clears
    err = 1'b0;
    tick(10);
    check("R4 fault held", fault, 1);
    check("R4 mod_dis_n low", mod_n, 0);
    check("R4 drv_en off", drv_en, 0);

    // R5: laser-off pulse clears the fault
    on_n = 1'b1;
    tick(1);
    on_n = 1'b0;
    tick(2);
    check("R5 fault cleared", fault, 0);
    tick(2);
    check("R5 drv_en back", drv_en, 1);

    // R3: interrupted error runs never latch
    err = 1'b1; tick(P - 1);
    err = 1'b0; tick(1);
    err = 1'b1; tick(P - 1);
    err = 1'b0; tick(5);
    check("R3 restart no fault", fault, 0);

    // R5: error during laser-off never counts
    on_n = 1'b1; err = 1'b1;
    tick(3 * P);
    check("R5 no fault while off", fault, 0);
    err = 1'b0; on_n = 1'b0;
    tick(4);

    // Random phase, scoreboard checks every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, P) == 0) err = ~err;
      on_n = ($urandom_range(0, 59) == 0) ? 1'b1 : 1'b0;
      if ($urandom_range(0, 79) == 0) pwr = ~pwr;
      tick(1);
    end

    // R7: power low under random activity
    pwr = 1'b0;
    tick(3);
    for (int i = 0; i < 200; i++) begin
      err  = 1'($urandom_range(0, 1));
      on_n = ($urandom_range(0, 9) == 0);
      tick(1);
      if (i > 2) check("R7 drv_en stays low", drv_en, 0);
    end

    report();
  end
endmodule